// File: doc/BRIEF.md
# Debug Watchpoint Trigger Unit

This block observes the data-side memory access bus of a soft processor and fires debug actions when an access meets a condition that software has programmed. Each of several independent channels holds an inclusive address window, an optional data pattern with a per-bit care mask, and a qualifier selecting loads, stores or both. All channels are evaluated in parallel on every valid bus cycle.

A channel that matches can drive any mix of four actions, each enabled by its own control bit. It can latch a sticky halt request for the run-control logic, switch the trace-capture gate on or off, pulse a shared external instrumentation trigger, and emit a per-channel event pulse that a performance counter can count. Channels are set up through a small write/read register port addressed by a channel index and a field code.

Top module: `wpt_unit`

## Requirements
- R1: After reset, halt_req, trace_en, ext_trig and evt_pulse are all low, and every channel's control field reads back as zero, so no channel is enabled.
- R2: A channel's address test passes when lo <= bus_addr <= hi, with both bounds inclusive. lo equal to hi matches exactly one address, and lo greater than hi never matches.
- R3: When control bit 3 (data compare) is set, a match also needs ((bus_data ^ pattern) & mask) == 0, so only bits with a mask bit of 1 are compared. When bit 3 is clear, bus_data has no effect on the match.
- R4: Control bit 1 permits loads (bus_store=0) and bit 2 permits stores (bus_store=1). With both set, either type matches. With neither set, the channel never matches.
- R5: A channel matches only in a cycle with bus_valid high and only while its control bit 0 (enable) is set.
- R6: Every action output is registered and reflects the access sampled at the previous rising clock edge. An access produces no output change before that edge.
- R7: A match on a channel with control bit 4 (halt) sets that channel's bit in the status field (field code 7, bit i = channel i). The bit stays set until software writes 1 to it, and writing 0 leaves it unchanged. halt_req is high whenever any status bit is set. A new match in the same cycle as a clear takes precedence.
- R8: A match on a channel with control bit 5 sets trace_en. A match on a channel with control bit 6 clears trace_en. If both happen in one access, trace_en is set. Otherwise trace_en holds its value.
- R9: ext_trig is high for one cycle after each access that matches at least one channel with control bit 7 (external trigger) set.
- R10: evt_pulse[i] is high for one cycle after an access that matches channel i while its control bit 8 (count) is set. A matching channel with bit 8 clear gives no pulse.
- R11: The channels are evaluated independently on the same access, and any subset of them may match at the same time.
- R12: A write selects the channel with reg_ch and the field with reg_field: 0 control, 1 lower bound, 2 upper bound, 3 data pattern, 4 data mask. reg_rdata returns the addressed field's current value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | CHW (2) | Channel index of the register access |
| reg_field | input | 3 | Field code of the register access |
| reg_wdata | input | RW (32) | Register write data |
| reg_rdata | output | RW (32) | Read data for the addressed field |
| bus_valid | input | 1 | Processor bus access valid this cycle |
| bus_store | input | 1 | 1 for a store, 0 for a load |
| bus_addr | input | AW (32) | Access address |
| bus_data | input | DW (32) | Access data (store data or load data) |
| halt_req | output | 1 | Sticky halt request to run control |
| trace_en | output | 1 | Trace collection gate |
| ext_trig | output | 1 | External instrumentation trigger pulse |
| evt_pulse | output | NUM_CH (4) | Per-channel countable event pulses |

## Verification
On every cycle the checker enforces a set of relations between the ports and the access bus. Event pulses, the external trigger, any change of the trace gate and a rising halt request may only follow a cycle in which bus_valid was high. A halt request stays high unless the status field is written, and it drops after a write that clears every status bit while no access is on the bus. The bench scenarios cover what depends on the programmed contents: where the window edges fall, which data bits the mask selects, the load/store qualifier, on-over-off priority for the trace gate, which channels match one access together, and register read-back.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  // Per-channel control word; en is bit 0, cnt is bit 8.
  typedef struct packed {
    logic cnt;
    logic ext;
    logic toff;
    logic ton;
    logic halt;
    logic dcmp;
    logic st;
    logic ld;
    logic en;
  } wpt_ctrl_t;

  localparam int CTRL_W = 9;

  typedef enum logic [2:0] {
    F_CTRL = 3'd0,
    F_LO   = 3'd1,
    F_HI   = 3'd2,
    F_DATA = 3'd3,
    F_MASK = 3'd4,
    F_STAT = 3'd7
  } wpt_field_e;

endpackage

// File: rtl/wpt_rst_sync.sv
module wpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wpt_regs.sv
module wpt_regs
  import wpt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int RW     = 32,
  parameter int CHW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CHW-1:0]    ch,
  input  logic [2:0]        field,
  input  logic [RW-1:0]     wdata,
  input  logic [NUM_CH-1:0] halt_stat,
  output logic [RW-1:0]     rdata,
  output wpt_ctrl_t         ctrl  [NUM_CH],
  output logic [AW-1:0]     lo    [NUM_CH],
  output logic [AW-1:0]     hi    [NUM_CH],
  output logic [DW-1:0]     cdata [NUM_CH],
  output logic [DW-1:0]     mask  [NUM_CH],
  output logic [NUM_CH-1:0] clr
);

  wpt_field_e fsel;
  assign fsel = wpt_field_e'(field);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    wpt_ctrl_t     ctrl_q;
    logic [AW-1:0] lo_q, hi_q;
    logic [DW-1:0] data_q, mask_q;
    logic          sel;
    logic          ce_ctrl, ce_lo, ce_hi, ce_data, ce_mask;

    always_comb begin
      sel     = we && (ch == CHW'(i));
      ce_ctrl = sel && (fsel == F_CTRL);
      ce_lo   = sel && (fsel == F_LO);
      ce_hi   = sel && (fsel == F_HI);
      ce_data = sel && (fsel == F_DATA);
      ce_mask = sel && (fsel == F_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        lo_q   <= '0;
        hi_q   <= '0;
        data_q <= '0;
        mask_q <= '0;
      end else begin
        if (ce_ctrl) ctrl_q <= wpt_ctrl_t'(wdata[CTRL_W-1:0]);
        if (ce_lo)   lo_q   <= wdata[AW-1:0];
        if (ce_hi)   hi_q   <= wdata[AW-1:0];
        if (ce_data) data_q <= wdata[DW-1:0];
        if (ce_mask) mask_q <= wdata[DW-1:0];
      end
    end

    assign ctrl[i]  = ctrl_q;
    assign lo[i]    = lo_q;
    assign hi[i]    = hi_q;
    assign cdata[i] = data_q;
    assign mask[i]  = mask_q;
  end

  assign clr = (we && (fsel == F_STAT)) ? wdata[NUM_CH-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (fsel == F_STAT) begin
      rdata[NUM_CH-1:0] = halt_stat;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (ch == CHW'(k)) begin
          case (fsel)
            F_CTRL:  rdata[CTRL_W-1:0] = ctrl[k];
            F_LO:    rdata[AW-1:0]     = lo[k];
            F_HI:    rdata[AW-1:0]     = hi[k];
            F_DATA:  rdata[DW-1:0]     = cdata[k];
            F_MASK:  rdata[DW-1:0]     = mask[k];
            default: rdata             = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/wpt_channel.sv
module wpt_channel
  import wpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  wpt_ctrl_t     cfg,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [DW-1:0] cdata,
  input  logic [DW-1:0] mask,
  input  logic          valid,
  input  logic          store,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          hit
);

  logic in_rng;
  logic data_ok;
  logic type_ok;

  always_comb begin
    in_rng  = (addr >= lo) && (addr <= hi);
    data_ok = !cfg.dcmp || (((data ^ cdata) & mask) == '0);
    type_ok = store ? cfg.st : cfg.ld;
    hit     = valid && cfg.en && in_rng && data_ok && type_ok;
  end

endmodule

// File: rtl/wpt_action.sv
module wpt_action #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] halt_en,
  input  logic [NUM_CH-1:0] ton_en,
  input  logic [NUM_CH-1:0] toff_en,
  input  logic [NUM_CH-1:0] ext_en,
  input  logic [NUM_CH-1:0] cnt_en,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] halt_stat,
  output logic              trace_en,
  output logic              ext_trig,
  output logic [NUM_CH-1:0] evt_pulse
);

  logic [NUM_CH-1:0] stat_q, stat_d;
  logic              trace_q, trace_d;
  logic              ext_q, ext_d;
  logic [NUM_CH-1:0] evt_q, evt_d;
  logic              any_on, any_off;

  always_comb begin
    any_on  = |(hit & ton_en);
    any_off = |(hit & toff_en);
    stat_d  = (stat_q & ~clr) | (hit & halt_en);
    if (any_on) begin
      trace_d = 1'b1;
    end else if (any_off) begin
      trace_d = 1'b0;
    end else begin
      trace_d = trace_q;
    end
    ext_d = |(hit & ext_en);
    evt_d = hit & cnt_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      trace_q <= 1'b0;
      ext_q   <= 1'b0;
      evt_q   <= '0;
    end else begin
      stat_q  <= stat_d;
      trace_q <= trace_d;
      ext_q   <= ext_d;
      evt_q   <= evt_d;
    end
  end

  assign halt_stat = stat_q;
  assign trace_en  = trace_q;
  assign ext_trig  = ext_q;
  assign evt_pulse = evt_q;

endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  localparam int RW    = (AW > DW) ? AW : DW,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CHW-1:0]    reg_ch,
  input  logic [2:0]        reg_field,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_store,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  output logic              halt_req,
  output logic              trace_en,
  output logic              ext_trig,
  output logic [NUM_CH-1:0] evt_pulse
);

  logic              srst_n;
  wpt_ctrl_t         ctrl  [NUM_CH];
  logic [AW-1:0]     lo    [NUM_CH];
  logic [AW-1:0]     hi    [NUM_CH];
  logic [DW-1:0]     cdata [NUM_CH];
  logic [DW-1:0]     mask  [NUM_CH];
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] halt_en, ton_en, toff_en, ext_en, cnt_en;
  logic [NUM_CH-1:0] halt_stat;

  wpt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wpt_regs #(
    .NUM_CH (NUM_CH),
    .AW     (AW),
    .DW     (DW),
    .RW     (RW),
    .CHW    (CHW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .we        (reg_we),
    .ch        (reg_ch),
    .field     (reg_field),
    .wdata     (reg_wdata),
    .halt_stat (halt_stat),
    .rdata     (reg_rdata),
    .ctrl      (ctrl),
    .lo        (lo),
    .hi        (hi),
    .cdata     (cdata),
    .mask      (mask),
    .clr       (clr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    wpt_channel #(.AW(AW), .DW(DW)) u_ch (
      .cfg   (ctrl[i]),
      .lo    (lo[i]),
      .hi    (hi[i]),
      .cdata (cdata[i]),
      .mask  (mask[i]),
      .valid (bus_valid),
      .store (bus_store),
      .addr  (bus_addr),
      .data  (bus_data),
      .hit   (hit[i])
    );
    assign halt_en[i] = ctrl[i].halt;
    assign ton_en[i]  = ctrl[i].ton;
    assign toff_en[i] = ctrl[i].toff;
    assign ext_en[i]  = ctrl[i].ext;
    assign cnt_en[i]  = ctrl[i].cnt;
  end

  wpt_action #(.NUM_CH(NUM_CH)) u_act (
    .clk       (clk),
    .rst_n     (srst_n),
    .hit       (hit),
    .halt_en   (halt_en),
    .ton_en    (ton_en),
    .toff_en   (toff_en),
    .ext_en    (ext_en),
    .cnt_en    (cnt_en),
    .clr       (clr),
    .halt_stat (halt_stat),
    .trace_en  (trace_en),
    .ext_trig  (ext_trig),
    .evt_pulse (evt_pulse)
  );

  assign halt_req = |halt_stat;

endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk #(
  parameter int NUM_CH = 4,
  parameter int RW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_field,
  input logic [RW-1:0]     reg_wdata,
  input logic              bus_valid,
  input logic              halt_req,
  input logic              trace_en,
  input logic              ext_trig,
  input logic [NUM_CH-1:0] evt_pulse
);

  logic stat_wr;
  assign stat_wr = reg_we && (reg_field == 3'd7);

  AST_EVT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |-> $past(bus_valid)); // R10

  AST_EXT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig |-> $past(bus_valid)); // R9

  AST_TRACE_MOVES_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trace_en) |-> $past(bus_valid)); // R8

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !stat_wr) |=> halt_req); // R7

  AST_HALT_RISE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(bus_valid)); // R5

  AST_HALT_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && (&reg_wdata[NUM_CH-1:0]) && !bus_valid) |=> !halt_req); // R7

endmodule

bind wpt_unit wpt_unit_chk #(.NUM_CH(NUM_CH), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_field (reg_field),
  .reg_wdata (reg_wdata),
  .bus_valid (bus_valid),
  .halt_req  (halt_req),
  .trace_en  (trace_en),
  .ext_trig  (ext_trig),
  .evt_pulse (evt_pulse)
);

// File: tb/wpt_unit_bench.sv
module wpt_unit_bench;

  localparam int NCH = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_ch;
  logic [2:0]  reg_field;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        bus_valid;
  logic        bus_store;
  logic [31:0] bus_addr;
  logic [31:0] bus_data;
  logic        halt_req;
  logic        trace_en;
  logic        ext_trig;
  logic [3:0]  evt_pulse;

  int n_chk = 0;
  int n_bad = 0;

  wpt_unit u_wpt_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_ch    (reg_ch),
    .reg_field (reg_field),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .bus_valid (bus_valid),
    .bus_store (bus_store),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .halt_req  (halt_req),
    .trace_en  (trace_en),
    .ext_trig  (ext_trig),
    .evt_pulse (evt_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [2:0] f, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 2'(ch); reg_field = f; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, logic [2:0] f, output logic [31:0] v);
    @(negedge clk);
    reg_ch = 2'(ch); reg_field = f;
    #1 v = reg_rdata;
  endtask

  task automatic prog(int ch, logic [31:0] c, logic [31:0] lo, logic [31:0] hi);
    wr(ch, 3'd1, lo);
    wr(ch, 3'd2, hi);
    wr(ch, 3'd0, c);
  endtask

  task automatic off_all();
    for (int i = 0; i < NCH; i++) wr(i, 3'd0, 32'h0);
  endtask

  // Drives one access; returns at the falling edge after the capturing edge.
  task automatic acc(bit st, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_store = st; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 halt_req", 32'(halt_req), 0);
    chk("R1 trace_en", 32'(trace_en), 0);
    chk("R1 ext_trig", 32'(ext_trig), 0);
    chk("R1 evt_pulse", 32'(evt_pulse), 0);
    for (int i = 0; i < NCH; i++) begin
      rd(i, 3'd0, v);
      chk("R1 ctrl", v, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(2, 3'd1, 32'h0000_1234);
    wr(2, 3'd4, 32'hF0F0_0FF0);
    wr(1, 3'd3, 32'hDEAD_BEEF);
    wr(3, 3'd0, 32'h0000_01FE);
    rd(2, 3'd1, v); chk("R12 lo ch2", v, 32'h0000_1234);
    rd(2, 3'd4, v); chk("R12 mask ch2", v, 32'hF0F0_0FF0);
    rd(1, 3'd3, v); chk("R12 data ch1", v, 32'hDEAD_BEEF);
    rd(3, 3'd0, v); chk("R12 ctrl ch3", v, 32'h0000_01FE);
    rd(0, 3'd1, v); chk("R12 lo ch0 untouched", v, 0);
    off_all();
  endtask

  task automatic t_range();
    prog(0, 32'h107, 32'h100, 32'h1FF);
    acc(0, 32'h100, 0); chk("R2 lower edge", 32'(evt_pulse[0]), 1);
    acc(1, 32'h1FF, 0); chk("R2 upper edge", 32'(evt_pulse[0]), 1);
    acc(0, 32'h0FF, 0); chk("R2 below", 32'(evt_pulse[0]), 0);
    acc(0, 32'h200, 0); chk("R2 above", 32'(evt_pulse[0]), 0);
    prog(0, 32'h107, 32'h40, 32'h40);
    acc(0, 32'h40, 0); chk("R2 single hit", 32'(evt_pulse[0]), 1);
    acc(0, 32'h41, 0); chk("R2 single miss", 32'(evt_pulse[0]), 0);
    prog(0, 32'h107, 32'h80, 32'h10);
    acc(0, 32'h80, 0); chk("R2 inverted at lo", 32'(evt_pulse[0]), 0);
    acc(0, 32'h10, 0); chk("R2 inverted at hi", 32'(evt_pulse[0]), 0);
    off_all();
  endtask

  task automatic t_timing();
    prog(0, 32'h107, 32'h100, 32'h1FF);
    @(negedge clk);
    bus_valid = 1'b1; bus_store = 1'b0; bus_addr = 32'h120; bus_data = 0;
    #1 chk("R6 before edge", 32'(evt_pulse), 0);
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R6 after edge", 32'(evt_pulse), 32'h1);
    @(negedge clk);
    chk("R6 one cycle", 32'(evt_pulse), 0);
    off_all();
  endtask

  task automatic t_data();
    prog(1, 32'h10F, 32'h0, 32'hFFFF_FFFF);
    wr(1, 3'd3, 32'h0000_AB00);
    wr(1, 3'd4, 32'h0000_FF00);
    acc(1, 32'h10, 32'h1234_AB77); chk("R3 masked equal", 32'(evt_pulse[1]), 1);
    acc(1, 32'h10, 32'h1234_AC00); chk("R3 masked differ", 32'(evt_pulse[1]), 0);
    acc(0, 32'h10, 32'hFFFF_ABFF); chk("R3 load masked equal", 32'(evt_pulse[1]), 1);
    wr(1, 3'd0, 32'h107);
    acc(1, 32'h10, 32'h0000_0000); chk("R3 compare off", 32'(evt_pulse[1]), 1);
    off_all();
  endtask

  task automatic t_type();
    prog(1, 32'h103, 32'h0, 32'hFFFF);
    acc(0, 32'h20, 0); chk("R4 load-only load", 32'(evt_pulse[1]), 1);
    acc(1, 32'h20, 0); chk("R4 load-only store", 32'(evt_pulse[1]), 0);
    wr(1, 3'd0, 32'h105);
    acc(1, 32'h20, 0); chk("R4 store-only store", 32'(evt_pulse[1]), 1);
    acc(0, 32'h20, 0); chk("R4 store-only load", 32'(evt_pulse[1]), 0);
    wr(1, 3'd0, 32'h101);
    acc(0, 32'h20, 0); chk("R4 none load", 32'(evt_pulse[1]), 0);
    acc(1, 32'h20, 0); chk("R4 none store", 32'(evt_pulse[1]), 0);
    off_all();
  endtask

  task automatic t_valid();
    prog(1, 32'h107, 32'h0, 32'hFFFF);
    @(negedge clk);
    bus_valid = 1'b0; bus_store = 1'b0; bus_addr = 32'h30; bus_data = 0;
    @(negedge clk);
    chk("R5 valid low", 32'(evt_pulse), 0);
    wr(1, 3'd0, 32'h106);
    acc(0, 32'h30, 0); chk("R5 disabled", 32'(evt_pulse), 0);
    off_all();
  endtask

  task automatic t_halt();
    logic [31:0] v;
    prog(2, 32'h017, 32'h500, 32'h500);
    chk("R7 idle", 32'(halt_req), 0);
    acc(0, 32'h500, 0); chk("R7 set", 32'(halt_req), 1);
    rd(2, 3'd7, v); chk("R7 status bit", v, 32'h4);
    repeat (3) @(negedge clk);
    chk("R7 sticky", 32'(halt_req), 1);
    wr(0, 3'd7, 32'h1);
    chk("R7 other bit clear", 32'(halt_req), 1);
    wr(0, 3'd7, 32'h0);
    chk("R7 zero write", 32'(halt_req), 1);
    wr(0, 3'd7, 32'h4);
    chk("R7 cleared", 32'(halt_req), 0);
    rd(0, 3'd7, v); chk("R7 status empty", v, 0);
    // clear and new match in one cycle: set wins
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 0; reg_field = 3'd7; reg_wdata = 32'h4;
    bus_valid = 1'b1; bus_store = 1'b1; bus_addr = 32'h500; bus_data = 0;
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    chk("R7 set beats clear", 32'(halt_req), 1);
    wr(0, 3'd7, 32'hF);
    off_all();
  endtask

  task automatic t_trace();
    prog(3, 32'h027, 32'h600, 32'h6FF);
    prog(0, 32'h047, 32'h700, 32'h7FF);
    acc(0, 32'h650, 0); chk("R8 on", 32'(trace_en), 1);
    repeat (2) @(negedge clk);
    chk("R8 hold", 32'(trace_en), 1);
    acc(1, 32'h750, 0); chk("R8 off", 32'(trace_en), 0);
    acc(0, 32'h800, 0); chk("R8 no match hold", 32'(trace_en), 0);
    prog(0, 32'h047, 32'h600, 32'h6FF);
    acc(0, 32'h610, 0); chk("R8 on wins", 32'(trace_en), 1);
    prog(3, 32'h000, 32'h600, 32'h6FF);
    acc(0, 32'h610, 0); chk("R8 off alone", 32'(trace_en), 0);
    off_all();
  endtask

  task automatic t_ext();
    prog(3, 32'h087, 32'h900, 32'h900);
    acc(0, 32'h900, 0); chk("R9 pulse", 32'(ext_trig), 1);
    @(negedge clk);
    chk("R9 one cycle", 32'(ext_trig), 0);
    acc(0, 32'h901, 0); chk("R9 no match", 32'(ext_trig), 0);
    prog(3, 32'h007, 32'h900, 32'h900);
    acc(0, 32'h900, 0); chk("R9 action off", 32'(ext_trig), 0);
    off_all();
  endtask

  task automatic t_multi();
    prog(0, 32'h107, 32'h0, 32'hFF);
    prog(1, 32'h107, 32'h80, 32'h17F);
    prog(2, 32'h007, 32'h0, 32'hFFFF);
    acc(0, 32'h90, 0);  chk("R11 both", 32'(evt_pulse), 32'h3);
    acc(0, 32'h10, 0);  chk("R11 ch0 only", 32'(evt_pulse), 32'h1);
    acc(1, 32'h150, 0); chk("R11 ch1 only", 32'(evt_pulse), 32'h2);
    acc(0, 32'h9000, 0); chk("R10 no count bit", 32'(evt_pulse), 0);
    chk("R10 no side halt", 32'(halt_req), 0);
    off_all();
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_ch = '0; reg_field = '0; reg_wdata = '0;
    bus_valid = 1'b0; bus_store = 1'b0; bus_addr = '0; bus_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_range();
    t_timing();
    t_data();
    t_type();
    t_valid();
    t_halt();
    t_trace();
    t_ext();
    t_multi();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule